// File: doc/BRIEF.md
# VLIW Molecule Dispatch Unit

This block sits between instruction fetch and the execution units of a statically scheduled wide-issue core. Fetch hands it one long instruction word (a molecule) at a time over a valid/ready handshake. The block holds the molecule and splits it into its 32-bit operations (atoms). Each atom goes to the functional unit fixed by its slot position: two integer ALUs, a floating-point unit, a load/store unit and a branch unit. There is no per-atom unit decode, no scheduler and no reorder or retire logic.

All real atoms of a molecule issue together, and only in a cycle when every unit they need is ready. While that is not the case, the whole molecule waits and fetch is stalled. Molecules issue strictly in the order they were accepted. After a molecule with a branch atom issues, issue pauses until the branch unit reports its outcome. A taken outcome discards any molecule that was accepted behind the branch.

Top module: `mol_dispatch`

## Requirements
- R1: Bit 0 of the molecule selects the format. With 0 (64-bit), bits [31:0] go to integer ALU 0, bits [63:32] go to integer ALU 1, and bits [127:64] are ignored. With 1 (128-bit), bits [31:0] go to the FP unit, [63:32] to integer ALU 0, [95:64] to load/store and [127:96] to the branch unit. Integer ALU 1 receives nothing in the 128-bit format. Unit index order on the issue ports is INT0=0, INT1=1, FP=2, LS=3, BR=4.
- R2: Atom fields are: opcode [31:24], condition-code update flag [23], destination register [22:17], source A [16:11] and source B [10:5]. Register fields are 6 bits wide. Each field appears unchanged on the target unit's issue outputs.
- R3: An all-zero atom is a NOP. For the slot at molecule bits [31:0], bit 0 is the format bit and is excluded from this test. A NOP raises no issue strobe and does not wait for its unit's ready input.
- R4: All non-NOP atoms of a molecule strobe in the same cycle. If any unit they target has its ready input low, no strobe of that molecule is raised in that cycle.
- R5: `mol_ready_o` is high exactly when no molecule is held, or when the held molecule issues in the current cycle. A held molecule is kept unchanged until it issues or is flushed.
- R6: Molecules issue in the order they were accepted, each at most once, and none overtakes another.
- R7: After a molecule with a non-NOP branch atom issues, no molecule issues until `br_done_i` is seen high. If `br_taken_i` is also high in that cycle, the held molecule and any molecule accepted in that same cycle are discarded without issuing. Issue may resume from the following cycle.
- R8: `br_done_i` has no effect while no branch is outstanding.
- R9: During and right after reset, `mol_ready_o` is high and no issue strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mol_i | input | 128 | Molecule word from fetch |
| mol_valid_i | input | 1 | Molecule word present |
| mol_ready_o | output | 1 | Block accepts a molecule this cycle |
| unit_rdy_i | input | 5 | Per-unit ready, index INT0,INT1,FP,LS,BR |
| br_done_i | input | 1 | Branch unit reports resolution of the outstanding branch |
| br_taken_i | input | 1 | Resolved branch was taken (valid with br_done_i) |
| iss_vld_o | output | 5 | Per-unit issue strobe |
| iss_opc_o | output | 5x8 | Per-unit opcode |
| iss_cc_o | output | 5 | Per-unit condition-code update flag |
| iss_dst_o | output | 5x6 | Per-unit destination register |
| iss_sa_o | output | 5x6 | Per-unit source A register |
| iss_sb_o | output | 5x6 | Per-unit source B register |

## Verification
The hardest situation to reach from the ports is a wrong-path molecule: one that has been accepted behind a branch but is still held when the branch resolves taken. The stimulus issues a branch molecule with every unit ready and presents the next molecule at once, so that it is accepted in the same cycle. It then holds `br_done_i` low for several cycles before raising it with `br_taken_i`. The case where the resolve cycle itself accepts a molecule is reached the same way with the hold register empty. Random phases then mix unit busy patterns, NOP slots, stray resolve pulses and both formats against a reference model that is compared every cycle.

// File: rtl/mdu_pkg.sv
`timescale 1ns/1ps
package mdu_pkg;
  localparam int OPC_W     = 8;
  localparam int REG_W     = 6;
  localparam int ATOM_W    = 32;
  localparam int NUM_SLOTS = 4;
  localparam int NUM_UNITS = 5;
  localparam int MOL_W     = NUM_SLOTS * ATOM_W;
  localparam int NARROW_SLOTS = 2;

  typedef enum logic [2:0] {
    U_INT0 = 3'd0,
    U_INT1 = 3'd1,
    U_FP   = 3'd2,
    U_LS   = 3'd3,
    U_BR   = 3'd4
  } unit_e;

  typedef struct packed {
    logic [OPC_W-1:0] opc;
    logic             cc;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src_a;
    logic [REG_W-1:0] src_b;
  } uop_t;

  localparam int UOP_W = $bits(uop_t);

  // fixed slot-to-unit routing
  function automatic unit_e slot_unit(logic wide, int slot);
    if (wide) begin
      case (slot)
        0:       return U_FP;
        1:       return U_INT0;
        2:       return U_LS;
        default: return U_BR;
      endcase
    end
    return (slot == 0) ? U_INT0 : U_INT1;
  endfunction
endpackage

// File: rtl/mdu_atom_dec.sv
`timescale 1ns/1ps
module mdu_atom_dec
  import mdu_pkg::*;
#(
  parameter bit FMT_SLOT = 1'b0
) (
  input  logic [ATOM_W-1:0] atom_i,
  output logic              nop_o,
  output uop_t              uop_o
);
  // slot carrying the format bit ignores it for NOP detection
  localparam logic [ATOM_W-1:0] IGN_MASK = FMT_SLOT ? ATOM_W'(1) : '0;

  assign nop_o = ((atom_i & ~IGN_MASK) == '0);
  assign uop_o = atom_i[ATOM_W-1 -: UOP_W];
endmodule

// File: rtl/mdu_slot_router.sv
`timescale 1ns/1ps
module mdu_slot_router
  import mdu_pkg::*;
(
  input  logic [MOL_W-1:0]              mol_i,
  output logic [NUM_UNITS-1:0]          need_o,
  output uop_t [NUM_UNITS-1:0]          uop_o
);
  logic                   wide;
  logic [NUM_SLOTS-1:0]   slot_nop;
  uop_t [NUM_SLOTS-1:0]   slot_uop;

  assign wide = mol_i[0];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    mdu_atom_dec #(.FMT_SLOT(s == 0)) u_dec (
      .atom_i (mol_i[s*ATOM_W +: ATOM_W]),
      .nop_o  (slot_nop[s]),
      .uop_o  (slot_uop[s])
    );
  end

  always_comb begin
    need_o = '0;
    uop_o  = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (wide || s < NARROW_SLOTS) begin
        uop_o[slot_unit(wide, s)]  = slot_uop[s];
        need_o[slot_unit(wide, s)] = !slot_nop[s];
      end
    end
  end
endmodule

// File: rtl/mdu_issue_ctl.sv
`timescale 1ns/1ps
module mdu_issue_ctl
  import mdu_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [MOL_W-1:0]     mol_i,
  input  logic                 mol_valid_i,
  output logic                 mol_ready_o,
  input  logic [NUM_UNITS-1:0] need_i,
  input  logic [NUM_UNITS-1:0] unit_rdy_i,
  input  logic                 br_done_i,
  input  logic                 br_taken_i,
  output logic [MOL_W-1:0]     hold_o,
  output logic                 hold_vld_o,
  output logic                 fire_o
);
  logic             hold_v_q;
  logic             pend_q;
  logic [MOL_W-1:0] hold_q;
  logic             blocked;
  logic             accept;
  logic             flush;

  assign blocked     = |(need_i & ~unit_rdy_i);
  assign fire_o      = hold_v_q && !pend_q && !blocked;
  assign mol_ready_o = !hold_v_q || fire_o;
  assign accept      = mol_valid_i && mol_ready_o;
  assign flush       = pend_q && br_done_i && br_taken_i;
  assign hold_o      = hold_q;
  assign hold_vld_o  = hold_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_q <= 1'b0;
      pend_q   <= 1'b0;
      hold_q   <= '0;
    end else begin
      if (fire_o)                  pend_q <= need_i[U_BR];
      else if (pend_q && br_done_i) pend_q <= 1'b0;

      if (flush)       hold_v_q <= 1'b0;
      else if (accept) hold_v_q <= 1'b1;
      else if (fire_o) hold_v_q <= 1'b0;

      if (accept) hold_q <= mol_i;
    end
  end

  p_hold_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_v_q && !fire_o && !flush) |=> (hold_v_q && $stable(hold_q)));

  p_branch_wait_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && need_i[U_BR]) |=> !fire_o);

  p_flush_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> !hold_v_q);

  p_stray_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && !fire_o && br_done_i) |=> !pend_q);
endmodule

// File: rtl/mol_dispatch.sv
`timescale 1ns/1ps
module mol_dispatch
  import mdu_pkg::*;
(
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [MOL_W-1:0]                     mol_i,
  input  logic                                 mol_valid_i,
  output logic                                 mol_ready_o,
  input  logic [NUM_UNITS-1:0]                 unit_rdy_i,
  input  logic                                 br_done_i,
  input  logic                                 br_taken_i,
  output logic [NUM_UNITS-1:0]                 iss_vld_o,
  output logic [NUM_UNITS-1:0][OPC_W-1:0]      iss_opc_o,
  output logic [NUM_UNITS-1:0]                 iss_cc_o,
  output logic [NUM_UNITS-1:0][REG_W-1:0]      iss_dst_o,
  output logic [NUM_UNITS-1:0][REG_W-1:0]      iss_sa_o,
  output logic [NUM_UNITS-1:0][REG_W-1:0]      iss_sb_o
);
  logic [MOL_W-1:0]      hold;
  logic                  hold_vld;
  logic                  fire;
  logic [NUM_UNITS-1:0]  need;
  uop_t [NUM_UNITS-1:0]  uop;

  mdu_issue_ctl u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mol_i       (mol_i),
    .mol_valid_i (mol_valid_i),
    .mol_ready_o (mol_ready_o),
    .need_i      (need),
    .unit_rdy_i  (unit_rdy_i),
    .br_done_i   (br_done_i),
    .br_taken_i  (br_taken_i),
    .hold_o      (hold),
    .hold_vld_o  (hold_vld),
    .fire_o      (fire)
  );

  mdu_slot_router u_route (
    .mol_i  (hold),
    .need_o (need),
    .uop_o  (uop)
  );

  assign iss_vld_o = fire ? need : '0;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign iss_opc_o[u] = uop[u].opc;
    assign iss_cc_o[u]  = uop[u].cc;
    assign iss_dst_o[u] = uop[u].dst;
    assign iss_sa_o[u]  = uop[u].src_a;
    assign iss_sb_o[u]  = uop[u].src_b;
  end

  p_all_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|iss_vld_o) |-> ((iss_vld_o & ~unit_rdy_i) == '0));

  p_narrow_map_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_vld && !hold[0]) |-> (iss_vld_o[U_FP] == 1'b0 && iss_vld_o[U_LS] == 1'b0
                                && iss_vld_o[U_BR] == 1'b0));

  p_wide_map_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_vld && hold[0]) |-> !iss_vld_o[U_INT1]);

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_vld |-> (iss_vld_o == '0 && mol_ready_o));
endmodule

// File: tb/mol_dispatch_bench.sv
`timescale 1ns/1ps
module mol_dispatch_bench;
  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [127:0]      mol = '0;
  logic              mol_valid = 1'b0;
  logic              mol_ready;
  logic [4:0]        unit_rdy = '1;
  logic              br_done = 1'b0;
  logic              br_taken = 1'b0;
  logic [4:0]        iss_vld;
  logic [4:0][7:0]   iss_opc;
  logic [4:0]        iss_cc;
  logic [4:0][5:0]   iss_dst, iss_sa, iss_sb;

  always #10 clk = ~clk;

  mol_dispatch u_mol_dispatch (
    .clk_i(clk), .rst_ni(rst_ni), .mol_i(mol), .mol_valid_i(mol_valid),
    .mol_ready_o(mol_ready), .unit_rdy_i(unit_rdy), .br_done_i(br_done),
    .br_taken_i(br_taken), .iss_vld_o(iss_vld), .iss_opc_o(iss_opc),
    .iss_cc_o(iss_cc), .iss_dst_o(iss_dst), .iss_sa_o(iss_sa), .iss_sb_o(iss_sb)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done_run = 0;
  string tag = "R9 reset";

  // reference state
  bit           m_hv = 0;
  bit           m_pend = 0;
  logic [127:0] m_hold = '0;
  int           m_issued = 0;

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // atom delivered to unit u (INT0,INT1,FP,LS,BR), zero if none
  function automatic logic [31:0] routed(logic [127:0] m, int u);
    logic [31:0] a;
    a = '0;
    if (m[0]) begin
      if (u == 2) a = {m[31:1], 1'b0};
      if (u == 0) a = m[63:32];
      if (u == 3) a = m[95:64];
      if (u == 4) a = m[127:96];
    end else begin
      if (u == 0) a = m[31:0];
      if (u == 1) a = m[63:32];
    end
    return a;
  endfunction

  task automatic step();
    bit   blk, fire, rdy, acc, fl;
    logic [4:0] want;
    #5;
    want = '0;
    for (int u = 0; u < 5; u++) want[u] = (routed(m_hold, u) != 0);
    blk  = |(want & ~unit_rdy);
    fire = rst_ni && m_hv && !m_pend && !blk;
    rdy  = !m_hv || fire;
    chk("fetch ready (R5)", 64'(mol_ready), 64'(rdy));
    chk("issue strobes (R4)", 64'(iss_vld), 64'(fire ? want : 5'b0));
    if (fire) begin
      for (int u = 0; u < 5; u++) begin
        if (want[u])
          chk("fields (R2)", 64'({iss_opc[u], iss_cc[u], iss_dst[u], iss_sa[u], iss_sb[u]}),
              64'(routed(m_hold, u) >> 5));
      end
      m_issued++;
    end
    if (rst_ni) begin
      acc = mol_valid && rdy;
      fl  = m_pend && br_done && br_taken;
      if (fire) m_pend = (routed(m_hold, 4) != 0);
      else if (m_pend && br_done) m_pend = 0;
      if (fl) m_hv = 0;
      else if (acc) m_hv = 1;
      else if (fire) m_hv = 0;
      if (acc) m_hold = mol;
    end
  endtask

  task automatic cyc(bit v, logic [127:0] m, logic [4:0] r, bit d, bit t);
    @(negedge clk);
    mol_valid = v; mol = m; unit_rdy = r; br_done = d; br_taken = t;
    step();
  endtask

  function automatic logic [31:0] atom(logic [7:0] opc, bit cc, logic [5:0] d,
                                       logic [5:0] a, logic [5:0] b);
    return {opc, cc, d, a, b, 5'b0};
  endfunction

  function automatic logic [127:0] rand_mol();
    logic [127:0] m;
    for (int s = 0; s < 4; s++) begin
      m[s*32 +: 32] = $urandom;
      if ($urandom % 4 == 0) m[s*32 +: 32] = '0;
    end
    m[0] = $urandom % 2;
    return m;
  endfunction

  logic [127:0] narrow_m, wide_m, nop_m, br_m, plain_m;

  initial begin
    narrow_m = {64'hDEAD_BEEF_F00D_CAFE, atom(8'h21, 1, 6'd3, 6'd4, 6'd5),
                atom(8'h12, 0, 6'd63, 6'd1, 6'd2)};
    wide_m   = {atom(8'h40, 0, 6'd0, 6'd7, 6'd8), atom(8'h33, 1, 6'd9, 6'd10, 6'd11),
                atom(8'h02, 1, 6'd12, 6'd13, 6'd14), atom(8'h81, 0, 6'd15, 6'd16, 6'd17) | 32'd1};
    nop_m    = {32'h0, 32'h0, atom(8'h05, 0, 6'd1, 6'd2, 6'd3), 32'h1};
    br_m     = {atom(8'h44, 0, 6'd0, 6'd20, 6'd0), 32'h0, atom(8'h06, 0, 6'd2, 6'd2, 6'd2), 32'h1};
    plain_m  = {64'h0, atom(8'h07, 1, 6'd30, 6'd31, 6'd32), atom(8'h08, 0, 6'd33, 6'd34, 6'd35)};

    tag = "R9 reset";
    cyc(1, narrow_m, '1, 0, 0);
    cyc(0, '0, '1, 0, 0);
    @(negedge clk); rst_ni = 1'b1;
    step();

    tag = "R1 narrow format";
    cyc(1, narrow_m, '1, 0, 0);
    cyc(0, '0, '1, 0, 0);
    cyc(0, '0, '1, 0, 0);

    tag = "R1 wide format";
    cyc(1, wide_m, '1, 0, 0);
    cyc(0, '0, '1, 0, 0);
    cyc(0, '0, '1, 1, 0);
    cyc(0, '0, '1, 0, 0);

    tag = "R3 NOP slots ignore busy units";
    cyc(1, nop_m, 5'b00101, 0, 0);
    cyc(0, '0, 5'b00101, 0, 0);
    cyc(0, '0, '1, 0, 0);

    tag = "R4 whole molecule waits";
    cyc(1, nop_m, 5'b11001, 0, 0);
    cyc(1, plain_m, 5'b11001, 0, 0);
    cyc(1, plain_m, 5'b11001, 0, 0);
    cyc(1, plain_m, 5'b11101, 0, 0);
    cyc(0, '0, '1, 0, 0);
    cyc(0, '0, '1, 0, 0);

    tag = "R7 taken flush of molecule behind branch";
    cyc(1, br_m, '1, 0, 0);
    cyc(1, plain_m, '1, 0, 0);
    cyc(0, '0, '1, 0, 0);
    cyc(0, '0, '1, 0, 0);
    cyc(0, '0, '1, 1, 1);
    cyc(0, '0, '1, 0, 0);
    cyc(0, '0, '1, 0, 0);

    tag = "R7 taken flush of molecule accepted in resolve cycle";
    cyc(1, br_m, '1, 0, 0);
    cyc(0, '0, '1, 0, 0);
    cyc(1, plain_m, '1, 1, 1);
    cyc(0, '0, '1, 0, 0);

    tag = "R7 not taken resumes in order";
    cyc(1, br_m, '1, 0, 0);
    cyc(1, plain_m, '1, 0, 0);
    cyc(0, '0, '1, 1, 0);
    cyc(0, '0, '1, 0, 0);
    cyc(0, '0, '1, 0, 0);

    tag = "R8 stray resolve ignored";
    cyc(1, plain_m, 5'b11110, 0, 0);
    cyc(0, '0, 5'b11110, 1, 1);
    cyc(0, '0, 5'b11110, 1, 0);
    cyc(0, '0, '1, 0, 0);
    cyc(0, '0, '1, 0, 0);

    tag = "R6 random in-order stream";
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] r;
      r = '0;
      for (int u = 0; u < 5; u++) r[u] = ($urandom % 4 != 0);
      cyc(($urandom % 10) < 7, rand_mol(), r, ($urandom % 5) == 0, $urandom % 2);
    end
    cyc(0, '0, '1, 1, 0);
    cyc(0, '0, '1, 0, 0);
    cyc(0, '0, '1, 0, 0);
    n_cmp++;
    if (m_issued < 200) begin
      n_bad++;
      $display("FAIL R6: issued molecules act=%0d exp>=200", m_issued);
    end

    done_run = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done_run) begin
      n_bad++;
      $display("FAIL watchdog (R6): act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule